// File: doc/BRIEF.md
# Indexed Register Window with Controller Sequencer

This block is the host-facing register front end of a network controller. The host sees a small window of 16-bit ports. It writes a register index into a pointer port, then reads or writes that register through one of two data ports. The data port it uses picks the bank: one port reaches the control/status bank and the other reaches the bus-configuration bank. Reading a dedicated port resets the controller's sequencing state.

The block owns control register 0. Its command bits start initialization, enter the running state, stop the controller and demand a transmit poll. A small sequencer tracks stopped, initializing, ready and running. It drives plain status outputs for the descriptor engines: a running level, an init-complete level, a one-cycle transmit kick, and the 32-bit init block address held in control registers 1 and 2.

Initialization is modelled as a fixed delay set by a parameter. Every other register is plain storage. Registers 88 and 89 are read-only and return an identification word. There is no streaming data path: every pin is a plain control or status signal, and every access is accepted in the cycle it is presented.

Top module: `ioreg_window`

## Requirements
- R1: Access decoding uses byte offsets: 0x10 is the control data port, 0x12 the pointer, 0x14 the reset port and 0x16 the bus-configuration data port. Every read access returns its data in `rd_data` with `rd_valid` high one cycle later. A read of any other offset returns 0, and a write to any other offset changes nothing.
- R2: The pointer is IDX_W (7) bits wide and readable, zero-extended. Writing 88 reads back 88, and upper write bits are dropped (0xFFD8 reads back 88).
- R3: A control data port access targets the control register named by the pointer. Every control register other than 0, 1, 2, 88 and 89 reads back the last value written to it.
- R4: The bus-configuration bank holds 32 registers, indexed by the low 5 bits of the pointer. It is separate from the control bank.
- R5: A read of the reset port returns 0 and forces control register 0 to 0x0004. Afterwards `running` and `init_done` are low. The pointer and both storage banks keep their contents.
- R6: Control register 0 has this layout: bit 0 init in progress, bit 1 running, bit 2 stopped, bit 3 transmit demand, bit 8 init done. All other bits read 0.
- R7: Writing bit 0 of control register 0 clears init done and starts initialization. Bit 0 reads 1 while initialization is under way. `init_done` rises exactly INIT_CYC clock edges after the write edge, and bit 0 then reads 0. Writing bit 0 while running leaves the running state.
- R8: Writing bit 1 while init done is set enters the running state: `running` goes high and the register reads 0x0102. Writing bit 1 before init done has no effect.
- R9: Bit 2 takes priority over all other bits in the same write. Writing it returns the sequencer to stopped, clears init done, and makes the register read 0x0004.
- R10: Writing bit 3 while running makes `tx_kick` high for exactly the one cycle after the write edge. Bit 3 reads 0 again afterwards. Writing bit 3 while not running gives no kick.
- R11: Control registers 1 and 2 are readable. `init_addr` equals {register 2, register 1}.
- R12: Control registers 88 and 89 are read-only. Together they form {4'h0, VERSION, 12'h003}, with 88 as the low half. With the default VERSION 0x2625, register 88 reads 0x5003 and register 89 reads 0x0262.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access strobe, one access per cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_off | input | 5 | Byte offset within the window |
| acc_wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data, one cycle after the access |
| rd_valid | output | 1 | Marks `rd_data` as holding a read result |
| running | output | 1 | Sequencer is in the running state |
| init_done | output | 1 | Initialization has completed |
| tx_kick | output | 1 | One-cycle transmit poll pulse |
| init_addr | output | 32 | Init block address from control registers 1 and 2 |

## Verification
The hardest cases to reach are the exact completion edge of initialization and the interaction of command bits with the current sequencer state. Every command write must therefore first walk the sequencer through the required path: init, wait, start. The bench counts edges from the init write while observing `init_done` at each falling edge, so an off-by-one in the delay is visible. It also repeats command writes from the stopped, initializing and running states. Exhaustive pointer and bank sweeps, including aliasing in the bus-configuration index, show that decoding never reaches the wrong bank.

// File: rtl/ioreg_pkg.sv
package ioreg_pkg;
  typedef enum logic [1:0] {
    CS_STOP  = 2'd0,
    CS_INIT  = 2'd1,
    CS_READY = 2'd2,
    CS_RUN   = 2'd3
  } ctl_state_e;

  typedef enum logic [1:0] {
    PORT_CDATA = 2'd0,
    PORT_PTR   = 2'd1,
    PORT_RST   = 2'd2,
    PORT_BDATA = 2'd3
  } port_e;

  localparam int unsigned B_INIT  = 0;
  localparam int unsigned B_START = 1;
  localparam int unsigned B_STOP  = 2;
  localparam int unsigned B_TDMD  = 3;
  localparam int unsigned B_DONE  = 8;
endpackage

// File: rtl/ioreg_regfile.sv
module ioreg_regfile #(
  parameter int DEPTH = 32,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ioreg_ptr.sv
module ioreg_ptr #(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [15:0]      wdata,
  output logic [IDX_W-1:0] idx
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  idx <= '0;
    else if (we) idx <= wdata[IDX_W-1:0];
  end
endmodule

// File: rtl/ioreg_ctl.sv
module ioreg_ctl
  import ioreg_pkg::*;
#(
  parameter int INIT_CYC = 8,
  localparam int CW      = $clog2(INIT_CYC + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        wr_en,
  input  logic [15:0] wdata,
  output logic [15:0] csr0,
  output logic        running,
  output logic        init_done,
  output logic        tx_kick
);
  ctl_state_e    state;
  logic [CW-1:0] cnt;
  logic          kick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= CS_STOP;
      cnt    <= '0;
      kick_q <= 1'b0;
    end else if (soft_rst) begin
      state  <= CS_STOP;
      cnt    <= '0;
      kick_q <= 1'b0;
    end else begin
      kick_q <= 1'b0;
      if (wr_en && wdata[B_STOP]) begin
        state <= CS_STOP;
      end else if (wr_en && wdata[B_INIT]) begin
        state <= CS_INIT;
        cnt   <= CW'(INIT_CYC - 1);
      end else begin
        case (state)
          CS_INIT: begin
            if (cnt == '0) state <= CS_READY;
            else           cnt   <= cnt - 1'b1;
          end
          CS_READY: if (wr_en && wdata[B_START]) state <= CS_RUN;
          CS_RUN:   if (wr_en && wdata[B_TDMD])  kick_q <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign running   = (state == CS_RUN);
  assign init_done = (state == CS_READY) || (state == CS_RUN);
  assign tx_kick   = kick_q;

  always_comb begin
    csr0           = '0;
    csr0[B_INIT]   = (state == CS_INIT);
    csr0[B_START]  = running;
    csr0[B_STOP]   = (state == CS_STOP);
    csr0[B_TDMD]   = kick_q;
    csr0[B_DONE]   = init_done;
  end
endmodule

// File: rtl/ioreg_window.sv
module ioreg_window
  import ioreg_pkg::*;
#(
  parameter int          IDX_W    = 7,
  parameter int          BCR_AW   = 5,
  parameter int          INIT_CYC = 8,
  parameter logic [15:0] VERSION  = 16'h2625
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_en,
  input  logic        acc_wr,
  input  logic [4:0]  acc_off,
  input  logic [15:0] acc_wdata,
  output logic [15:0] rd_data,
  output logic        rd_valid,
  output logic        running,
  output logic        init_done,
  output logic        tx_kick,
  output logic [31:0] init_addr
);
  localparam int CSR_DEPTH = 1 << IDX_W;
  localparam int BCR_DEPTH = 1 << BCR_AW;
  localparam logic [IDX_W-1:0] IX_CTL   = IDX_W'(0);
  localparam logic [IDX_W-1:0] IX_ALO   = IDX_W'(1);
  localparam logic [IDX_W-1:0] IX_AHI   = IDX_W'(2);
  localparam logic [IDX_W-1:0] IX_IDLO  = IDX_W'(88);
  localparam logic [IDX_W-1:0] IX_IDHI  = IDX_W'(89);
  localparam logic [31:0]      ID_WORD  = {4'h0, VERSION, 12'h003};

  logic             hit;
  port_e            port;
  logic             wr_hit, rd_hit;
  logic [IDX_W-1:0] idx;
  logic             special;
  logic [15:0]      csr0, csr_store, bcr_store;
  logic [15:0]      addr_lo, addr_hi;
  logic [15:0]      rd_mux;
  logic             soft_rst;

  assign hit    = acc_en && acc_off[4] && !acc_off[3] && !acc_off[0];
  assign port   = port_e'(acc_off[2:1]);
  assign wr_hit = hit && acc_wr;
  assign rd_hit = hit && !acc_wr;
  assign soft_rst = rd_hit && (port == PORT_RST);

  assign special = (idx == IX_CTL) || (idx == IX_ALO) || (idx == IX_AHI) ||
                   (idx == IX_IDLO) || (idx == IX_IDHI);

  ioreg_ptr #(.IDX_W(IDX_W)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_hit && (port == PORT_PTR)),
    .wdata (acc_wdata),
    .idx   (idx)
  );

  ioreg_ctl #(.INIT_CYC(INIT_CYC)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .wr_en     (wr_hit && (port == PORT_CDATA) && (idx == IX_CTL)),
    .wdata     (acc_wdata),
    .csr0      (csr0),
    .running   (running),
    .init_done (init_done),
    .tx_kick   (tx_kick)
  );

  ioreg_regfile #(.DEPTH(CSR_DEPTH), .DW(16)) u_csr_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_hit && (port == PORT_CDATA) && !special),
    .waddr (idx),
    .wdata (acc_wdata),
    .raddr (idx),
    .rdata (csr_store)
  );

  ioreg_regfile #(.DEPTH(BCR_DEPTH), .DW(16)) u_bcr_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_hit && (port == PORT_BDATA)),
    .waddr (idx[BCR_AW-1:0]),
    .wdata (acc_wdata),
    .raddr (idx[BCR_AW-1:0]),
    .rdata (bcr_store)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_lo <= '0;
      addr_hi <= '0;
    end else if (wr_hit && (port == PORT_CDATA)) begin
      if (idx == IX_ALO) addr_lo <= acc_wdata;
      if (idx == IX_AHI) addr_hi <= acc_wdata;
    end
  end

  assign init_addr = {addr_hi, addr_lo};

  always_comb begin
    rd_mux = '0;
    if (hit) begin
      case (port)
        PORT_PTR:   rd_mux = 16'(idx);
        PORT_RST:   rd_mux = '0;
        PORT_BDATA: rd_mux = bcr_store;
        default: begin
          if      (idx == IX_CTL)  rd_mux = csr0;
          else if (idx == IX_ALO)  rd_mux = addr_lo;
          else if (idx == IX_AHI)  rd_mux = addr_hi;
          else if (idx == IX_IDLO) rd_mux = ID_WORD[15:0];
          else if (idx == IX_IDHI) rd_mux = ID_WORD[31:16];
          else                     rd_mux = csr_store;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= acc_en && !acc_wr;
      if (acc_en && !acc_wr) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/ioreg_window_chk.sv
module ioreg_window_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_en,
  input logic       acc_wr,
  input logic [4:0] acc_off,
  input logic       rd_valid,
  input logic       running,
  input logic       init_done,
  input logic       tx_kick
);
  // R1
  rd_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(acc_en && !acc_wr));

  // R5
  reset_port_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && acc_off == 5'h14) |=> (!running && !init_done));

  // R8
  run_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> $past(init_done));

  // R8
  run_keeps_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> init_done);

  // R10
  kick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_kick |=> !tx_kick);

  // R10
  kick_when_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_kick |-> running);
endmodule

bind ioreg_window ioreg_window_chk u_chk (.*);

// File: tb/tb_ioreg_window.sv
module tb_ioreg_window;
  localparam int CLK_PERIOD = 10;
  localparam int INIT_CYC   = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_en, acc_wr;
  logic [4:0]  acc_off;
  logic [15:0] acc_wdata;
  logic [15:0] rd_data;
  logic        rd_valid, running, init_done, tx_kick;
  logic [31:0] init_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ioreg_window #(.INIT_CYC(INIT_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_off(acc_off), .acc_wdata(acc_wdata), .rd_data(rd_data),
    .rd_valid(rd_valid), .running(running), .init_done(init_done),
    .tx_kick(tx_kick), .init_addr(init_addr)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] off, input logic [15:0] d);
    acc_en = 1'b1; acc_wr = 1'b1; acc_off = off; acc_wdata = d;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] off, output logic [15:0] d, output logic v);
    acc_en = 1'b1; acc_wr = 1'b0; acc_off = off;
    @(negedge clk);
    d = rd_data; v = rd_valid;
    acc_en = 1'b0;
  endtask

  task automatic wr_csr(input int i, input logic [15:0] d);
    wr(5'h12, 16'(i)); wr(5'h10, d);
  endtask

  task automatic rd_csr(input int i, output logic [15:0] d);
    logic v;
    wr(5'h12, 16'(i)); rd(5'h10, d, v);
  endtask

  function automatic logic [15:0] fval(input int i);
    return 16'(i * 16'h0123) ^ 16'hA5A5;
  endfunction

  function automatic logic [15:0] gval(input int i);
    return 16'(i * 16'h0811) ^ 16'h3C3C;
  endfunction

  task automatic bring_up();
    wr_csr(0, 16'h0001);
    repeat (INIT_CYC + 1) @(negedge clk);
    wr(5'h10, 16'h0002);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic v;
    logic bad;
    acc_en = 0; acc_wr = 0; acc_off = 0; acc_wdata = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 R6 reset state
    check(!running && !init_done && !tx_kick && !rd_valid, "R5 idle outputs",
          {running, init_done, tx_kick, rd_valid}, 0);
    rd_csr(0, d);
    check(d == 16'h0004, "R6 csr0 after reset", d, 16'h0004);

    // R2 pointer sweep
    bad = 0;
    for (int i = 0; i < 128; i++) begin
      wr(5'h12, 16'(i)); rd(5'h12, d, v);
      if (d != 16'(i) || !v) begin bad = 1; check(0, "R2 pointer readback", d, i); end
    end
    check(!bad, "R2 pointer sweep", bad, 0);
    wr(5'h12, 16'hFFD8); rd(5'h12, d, v);
    check(d == 16'd88, "R2 pointer truncation", d, 88);

    // R3 control bank sweep
    for (int i = 3; i < 128; i++)
      if (i != 88 && i != 89) wr_csr(i, fval(i));
    bad = 0;
    for (int i = 3; i < 128; i++)
      if (i != 88 && i != 89) begin
        rd_csr(i, d);
        if (d != fval(i)) begin bad = 1; check(0, "R3 control bank", d, fval(i)); end
      end
    check(!bad, "R3 control bank sweep", bad, 0);

    // R4 bus configuration bank sweep
    for (int i = 0; i < 32; i++) begin wr(5'h12, 16'(i)); wr(5'h16, gval(i)); end
    bad = 0;
    for (int i = 0; i < 32; i++) begin
      wr(5'h12, 16'(i)); rd(5'h16, d, v);
      if (d != gval(i)) begin bad = 1; check(0, "R4 bus cfg bank", d, gval(i)); end
    end
    check(!bad, "R4 bus cfg sweep", bad, 0);
    rd_csr(5, d);
    check(d == fval(5), "R4 control bank untouched", d, fval(5));
    wr(5'h12, 16'd35); wr(5'h16, 16'h7E57);
    wr(5'h12, 16'd3);  rd(5'h16, d, v);
    check(d == 16'h7E57, "R4 low 5 bit index alias", d, 16'h7E57);
    rd_csr(35, d);
    check(d == fval(35), "R4 control 35 independent", d, fval(35));

    // R12 identification
    rd_csr(88, d);
    check(d == 16'h5003, "R12 id low", d, 16'h5003);
    rd_csr(89, d);
    check(d == 16'h0262, "R12 id high", d, 16'h0262);
    wr_csr(88, 16'hFFFF); rd(5'h10, d, v);
    check(d == 16'h5003, "R12 id read-only", d, 16'h5003);

    // R11 init block address
    wr_csr(1, 16'h1234); wr_csr(2, 16'hABCD);
    check(init_addr == 32'hABCD1234, "R11 init_addr", init_addr, 32'hABCD1234);
    rd_csr(1, d);
    check(d == 16'h1234, "R11 reg1 readback", d, 16'h1234);

    // R1 unused offsets
    wr(5'h12, 16'd9);
    rd(5'h18, d, v);
    check(d == 16'h0 && v, "R1 unused offset read", {v, d}, 32'h10000);
    wr(5'h1A, 16'd44); wr(5'h11, 16'd44);
    rd(5'h12, d, v);
    check(d == 16'd9, "R1 unused write ignored", d, 9);
    @(negedge clk);
    check(!rd_valid, "R1 rd_valid idle", rd_valid, 0);

    // R8 start before init ignored, R10 demand while stopped ignored
    wr_csr(0, 16'h0002);
    check(!running, "R8 start ignored when stopped", running, 0);
    wr(5'h10, 16'h0008);
    check(!tx_kick, "R10 no kick when stopped", tx_kick, 0);
    rd(5'h10, d, v);
    check(d == 16'h0004, "R8 csr0 still stopped", d, 16'h0004);

    // R7 init timing
    wr(5'h10, 16'h0001);
    bad = 0;
    for (int k = 1; k <= INIT_CYC; k++) begin
      @(negedge clk);
      if (init_done != (k == INIT_CYC)) begin
        bad = 1; check(0, "R7 init_done edge", init_done, k == INIT_CYC);
      end
    end
    check(!bad, "R7 init delay exact", bad, 0);
    rd(5'h10, d, v);
    check(d == 16'h0100, "R7 csr0 init done", d, 16'h0100);

    // R7 init bit visible while in progress
    wr(5'h10, 16'h0001);
    check(!init_done, "R7 init clears done", init_done, 0);
    rd(5'h10, d, v);
    check(d == 16'h0001, "R7 init bit in progress", d, 16'h0001);
    repeat (INIT_CYC) @(negedge clk);

    // R8 start
    wr(5'h10, 16'h0002);
    check(running, "R8 running", running, 1);
    rd(5'h10, d, v);
    check(d == 16'h0102, "R8 csr0 running", d, 16'h0102);

    // R10 transmit demand pulse
    wr(5'h10, 16'h0008);
    check(tx_kick, "R10 kick high", tx_kick, 1);
    @(negedge clk);
    check(!tx_kick, "R10 kick one cycle", tx_kick, 0);
    rd(5'h10, d, v);
    check(d == 16'h0102, "R10 demand bit cleared", d, 16'h0102);

    // R9 stop priority
    wr(5'h10, 16'h000F);
    check(!running && !init_done && !tx_kick, "R9 stop wins",
          {running, init_done, tx_kick}, 0);
    rd(5'h10, d, v);
    check(d == 16'h0004, "R9 csr0 stopped", d, 16'h0004);

    // R7 init while running leaves running
    bring_up();
    check(running, "R7 precondition running", running, 1);
    wr(5'h10, 16'h0001);
    check(!running && !init_done, "R7 init leaves run", {running, init_done}, 0);
    repeat (INIT_CYC) @(negedge clk);

    // R5 reset port
    wr(5'h10, 16'h0002);
    wr(5'h12, 16'd7);
    rd(5'h14, d, v);
    check(d == 16'h0 && v, "R5 reset port reads 0", {v, d}, 32'h10000);
    check(!running && !init_done, "R5 outputs after reset port",
          {running, init_done}, 0);
    rd(5'h12, d, v);
    check(d == 16'd7, "R5 pointer kept", d, 7);
    rd(5'h10, d, v);
    check(d == fval(7), "R5 storage kept", d, fval(7));
    rd_csr(0, d);
    check(d == 16'h0004, "R5 csr0 after reset port", d, 16'h0004);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule